// File: doc/BRIEF.md
# Raster Timing Generator with Line and Frame Interrupts

This block keeps the horizontal dot position and the vertical line position of a 342-dot NTSC raster. From the dot position it decodes which part of the line is being scanned: the visible picture, the border, blanking, horizontal sync or the color-burst window. A master-clock divider sets the dot rate. By default it gives one dot for every ten master clocks: a divide-by-five stage feeds a counter that emits a dot every second tick, so one CPU cycle of fifteen master clocks covers one and a half dots.

Two interrupt sources share one request line. A down-counter runs through the visible lines and raises a line interrupt when it underflows, so software can schedule raster effects every N+1 lines. A frame interrupt is raised when the line count leaves the visible area. The request stays high until an acknowledge strobe arrives. A horizontal scroll value presented by software is captured only at the boundary between lines, so every dot of a line uses the same scroll. The scroll returns to zero at the frame interrupt, which means the first visible line is never scrolled.

Top module: `raster_timer`

## Requirements
- R1: `dot_count` steps by one every DOT_DIV master clocks and wraps from 341 to 0. At each wrap `line_count` steps by one and wraps from TOTAL_LINES-1 to 0.
- R2: `region` reflects the current `dot_count` using the encoding 0 = visible (dots 0..255), 1 = border (256..270 and 329..341), 2 = blanking (271..278, 305..306 and 321..328), 3 = sync (279..304) and 4 = burst (307..320). `v_active` is high exactly while `line_count` < ACTIVE_LINES.
- R3: With reload value N, a line interrupt is raised on the step into line L, for 1 <= L <= ACTIVE_LINES, exactly when L is a multiple of N+1. N = 0 therefore gives an interrupt on every line from line 1 onwards.
- R4: No line interrupt is raised on the step into line 0 or into any line after ACTIVE_LINES. On those steps the down-counter reloads from `lc_reload`, and reset also loads it.
- R5: A frame interrupt is raised on the step into line ACTIVE_LINES+1, so `line_count` reads 193 with the default parameters when it appears.
- R6: `scroll_eff` takes the value of `scroll_pend` at each step into lines 1..ACTIVE_LINES-1. It never changes while `dot_count` is not 0, so a write made partway through a line shows only from the next line.
- R7: `scroll_eff` is cleared on the step into line ACTIVE_LINES+1 and on reset, so line 0 always uses a scroll of 0. It holds its value on the step into line ACTIVE_LINES.
- R8: `irq` stays high until `irq_ack` is sampled high, and the acknowledge clears both pending sources. A new interrupt raised in the same cycle as the acknowledge takes priority.
- R9: While reset is held, `dot_count`, `line_count`, `scroll_eff` and `irq` are 0, `region` is 0 and `v_active` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| lc_reload | input | RELOAD_W | Reload value for the line down-counter |
| scroll_pend | input | SCROLL_W | Horizontal scroll value offered by software |
| irq_ack | input | 1 | Interrupt acknowledge strobe |
| dot_count | output | 9 | Current dot within the line |
| line_count | output | 9 | Current line within the frame |
| region | output | 3 | Horizontal region code |
| v_active | output | 1 | Current line is a visible line |
| irq | output | 1 | Interrupt request (line or frame) |
| scroll_eff | output | SCROLL_W | Scroll value in effect for the current line |

## Verification
The hardest case to reach is the interplay of reload values with the frame edges. A reload larger than the visible line count must give no line interrupt at all, and a reload change made late in one frame must take effect only from the next line-0 reload. To reach it quickly, the bench shrinks the frame to twelve lines with six visible and runs one dot per clock. It sweeps one reload value per frame, changing the value in the last line of each frame. It also writes a new scroll value in the middle of every line, so that the within-line stability of the scroll and its clearing at the frame edge are both exercised on every line.

// File: rtl/raster_pkg.sv
package raster_pkg;

    localparam int DOT_W      = 9;
    localparam int LINE_W     = 9;
    localparam int LINE_DOTS  = 342;

    // exclusive upper bounds of each horizontal segment, in scan order
    localparam int SEG_PIC    = 256;
    localparam int SEG_RBORD  = 271;
    localparam int SEG_RBLANK = 279;
    localparam int SEG_SYNC   = 305;
    localparam int SEG_LBL1   = 307;
    localparam int SEG_BURST  = 321;
    localparam int SEG_LBL2   = 329;

    typedef enum logic [2:0] {
        RG_PICTURE = 3'd0,
        RG_BORDER  = 3'd1,
        RG_BLANK   = 3'd2,
        RG_SYNC    = 3'd3,
        RG_BURST   = 3'd4
    } region_e;

    typedef struct packed {
        logic              step;
        logic [LINE_W-1:0] line;
    } line_evt_t;

    function automatic region_e region_of(input logic [DOT_W-1:0] d);
        if (d < DOT_W'(SEG_PIC))         return RG_PICTURE;
        else if (d < DOT_W'(SEG_RBORD))  return RG_BORDER;
        else if (d < DOT_W'(SEG_RBLANK)) return RG_BLANK;
        else if (d < DOT_W'(SEG_SYNC))   return RG_SYNC;
        else if (d < DOT_W'(SEG_LBL1))   return RG_BLANK;
        else if (d < DOT_W'(SEG_BURST))  return RG_BURST;
        else if (d < DOT_W'(SEG_LBL2))   return RG_BLANK;
        else                             return RG_BORDER;
    endfunction

endpackage

// File: rtl/dot_divider.sv
module dot_divider #(
    parameter int DIV = 10
) (
    input  logic clk,
    input  logic rst,
    output logic dot_en
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign dot_en = (cnt == LAST);
endmodule

// File: rtl/raster_counters.sv
module raster_counters
    import raster_pkg::*;
#(
    parameter int TOTAL_LINES  = 262,
    parameter int ACTIVE_LINES = 192
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dot_en,
    output logic [DOT_W-1:0]  dot,
    output logic [LINE_W-1:0] line,
    output region_e           region,
    output logic              v_active,
    output line_evt_t         evt
);
    localparam logic [DOT_W-1:0]  DOT_LAST  = DOT_W'(LINE_DOTS - 1);
    localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(TOTAL_LINES - 1);
    localparam logic [LINE_W-1:0] VIS_END   = LINE_W'(ACTIVE_LINES);

    logic              wrap;
    logic [DOT_W-1:0]  dot_next;
    logic [LINE_W-1:0] line_next;

    always_comb begin
        wrap      = (dot == DOT_LAST);
        dot_next  = wrap ? '0 : dot + 1'b1;
        line_next = line;
        if (wrap) line_next = (line == LINE_LAST) ? '0 : line + 1'b1;
        evt.step  = dot_en && wrap;
        evt.line  = line_next;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dot      <= '0;
            line     <= '0;
            region   <= RG_PICTURE;
            v_active <= 1'b1;
        end else if (dot_en) begin
            dot      <= dot_next;
            line     <= line_next;
            region   <= region_of(dot_next);
            v_active <= (line_next < VIS_END);
        end
    end
endmodule

// File: rtl/line_irq_unit.sv
module line_irq_unit
    import raster_pkg::*;
#(
    parameter int ACTIVE_LINES = 192,
    parameter int RELOAD_W     = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  line_evt_t           evt,
    input  logic [RELOAD_W-1:0] reload,
    input  logic                ack,
    output logic                irq
);
    localparam logic [LINE_W-1:0] VIS_LAST   = LINE_W'(ACTIVE_LINES);
    localparam logic [LINE_W-1:0] FRAME_LINE = LINE_W'(ACTIVE_LINES + 1);

    logic [RELOAD_W-1:0] cnt;
    logic                in_window;
    logic                line_hit;
    logic                frame_hit;
    logic                pend_line;
    logic                pend_frame;

    always_comb begin
        in_window = (evt.line != '0) && (evt.line <= VIS_LAST);
        line_hit  = evt.step && in_window && (cnt == '0);
        frame_hit = evt.step && (evt.line == FRAME_LINE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= reload;
        end else if (evt.step) begin
            if (!in_window || cnt == '0) cnt <= reload;
            else                         cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_line  <= 1'b0;
            pend_frame <= 1'b0;
        end else begin
            if (line_hit)  pend_line  <= 1'b1;
            else if (ack)  pend_line  <= 1'b0;
            if (frame_hit) pend_frame <= 1'b1;
            else if (ack)  pend_frame <= 1'b0;
        end
    end

    assign irq = pend_line | pend_frame;
endmodule

// File: rtl/scroll_latch.sv
module scroll_latch
    import raster_pkg::*;
#(
    parameter int ACTIVE_LINES = 192,
    parameter int SCROLL_W     = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  line_evt_t           evt,
    input  logic [SCROLL_W-1:0] pend,
    output logic [SCROLL_W-1:0] eff
);
    localparam logic [LINE_W-1:0] VIS_LAST   = LINE_W'(ACTIVE_LINES);
    localparam logic [LINE_W-1:0] FRAME_LINE = LINE_W'(ACTIVE_LINES + 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            eff <= '0;
        end else if (evt.step) begin
            if (evt.line == FRAME_LINE)
                eff <= '0;
            else if (evt.line != '0 && evt.line < VIS_LAST)
                eff <= pend;
        end
    end
endmodule

// File: rtl/raster_timer.sv
module raster_timer
    import raster_pkg::*;
#(
    parameter int DOT_DIV      = 10,
    parameter int TOTAL_LINES  = 262,
    parameter int ACTIVE_LINES = 192,
    parameter int RELOAD_W     = 8,
    parameter int SCROLL_W     = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [RELOAD_W-1:0] lc_reload,
    input  logic [SCROLL_W-1:0] scroll_pend,
    input  logic                irq_ack,
    output logic [8:0]          dot_count,
    output logic [8:0]          line_count,
    output logic [2:0]          region,
    output logic                v_active,
    output logic                irq,
    output logic [SCROLL_W-1:0] scroll_eff
);
    logic      dot_en;
    line_evt_t evt;
    region_e   reg_q;
    logic      line_step;

    dot_divider #(.DIV(DOT_DIV)) u_div (
        .clk    (clk),
        .rst    (rst),
        .dot_en (dot_en)
    );

    raster_counters #(
        .TOTAL_LINES  (TOTAL_LINES),
        .ACTIVE_LINES (ACTIVE_LINES)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .dot_en   (dot_en),
        .dot      (dot_count),
        .line     (line_count),
        .region   (reg_q),
        .v_active (v_active),
        .evt      (evt)
    );

    line_irq_unit #(
        .ACTIVE_LINES (ACTIVE_LINES),
        .RELOAD_W     (RELOAD_W)
    ) u_irq (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .reload (lc_reload),
        .ack    (irq_ack),
        .irq    (irq)
    );

    scroll_latch #(
        .ACTIVE_LINES (ACTIVE_LINES),
        .SCROLL_W     (SCROLL_W)
    ) u_scr (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt),
        .pend (scroll_pend),
        .eff  (scroll_eff)
    );

    assign region    = reg_q;
    assign line_step = evt.step;
endmodule

// File: rtl/raster_timer_chk.sv
module raster_timer_chk #(
    parameter int TOTAL_LINES = 262,
    parameter int SCROLL_W    = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                irq_ack,
    input logic                line_step,
    input logic [8:0]          dot_count,
    input logic [8:0]          line_count,
    input logic [2:0]          region,
    input logic                irq,
    input logic [SCROLL_W-1:0] scroll_eff
);
    AST_DOT_RANGE: assert property (@(posedge clk) disable iff (rst)
        dot_count <= 9'd341); // R1

    AST_LINE_RANGE: assert property (@(posedge clk) disable iff (rst)
        line_count < 9'(TOTAL_LINES)); // R1

    AST_DOT_STEP: assert property (@(posedge clk) disable iff (rst)
        (dot_count != $past(dot_count)) |->
            ((dot_count == $past(dot_count) + 9'd1) ||
             (dot_count == 9'd0 && $past(dot_count) == 9'd341))); // R1

    AST_SYNC_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (region == 3'd3) |-> (dot_count >= 9'd279 && dot_count <= 9'd304)); // R2

    AST_SCROLL_STEADY: assert property (@(posedge clk) disable iff (rst)
        (dot_count != 9'd0) |-> $stable(scroll_eff)); // R6

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_ack) |=> irq); // R8

    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !line_step) |=> !irq); // R8
endmodule

bind raster_timer raster_timer_chk #(
    .TOTAL_LINES (TOTAL_LINES),
    .SCROLL_W    (SCROLL_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .irq_ack    (irq_ack),
    .line_step  (line_step),
    .dot_count  (dot_count),
    .line_count (line_count),
    .region     (region),
    .irq        (irq),
    .scroll_eff (scroll_eff)
);

// File: tb/sim_raster_timer.sv
module sim_raster_timer;
    localparam int T  = 12;
    localparam int A  = 6;
    localparam int LD = 342;
    localparam int NF = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] lc_reload = 8'd0;
    logic [7:0] scroll_pend = 8'd0;
    logic       irq_ack = 1'b0;
    logic [8:0] dot_count, line_count;
    logic [2:0] region;
    logic       v_active, irq;
    logic [7:0] scroll_eff;

    logic [8:0] d1, l1;
    logic [2:0] r1;
    logic       va1, irq1;
    logic [7:0] s1;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    raster_timer #(.DOT_DIV(1), .TOTAL_LINES(T), .ACTIVE_LINES(A)) u0 (
        .clk(clk), .rst(rst), .lc_reload(lc_reload), .scroll_pend(scroll_pend),
        .irq_ack(irq_ack), .dot_count(dot_count), .line_count(line_count),
        .region(region), .v_active(v_active), .irq(irq), .scroll_eff(scroll_eff));

    raster_timer #(.DOT_DIV(3), .TOTAL_LINES(T), .ACTIVE_LINES(A)) u1 (
        .clk(clk), .rst(rst), .lc_reload(8'd0), .scroll_pend(8'd0),
        .irq_ack(1'b0), .dot_count(d1), .line_count(l1),
        .region(r1), .v_active(va1), .irq(irq1), .scroll_eff(s1));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (time %0t)", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_region(input int d);
        if (d < 256) return 0;
        if (d < 271) return 1;
        if (d < 279) return 2;
        if (d < 305) return 3;
        if (d < 307) return 2;
        if (d < 321) return 4;
        if (d < 329) return 2;
        return 1;
    endfunction

    function automatic bit fires(input int ln, input int n);
        return (ln >= 1) && (ln <= A) && ((ln % (n + 1)) == 0);
    endfunction

    function automatic int pend_val(input int ln);
        return (ln * 37 + 5) % 256;
    endfunction

    function automatic int exp_scroll(input int ln);
        if (ln >= 1 && ln <= A - 1) return pend_val(ln - 1);
        if (ln == A) return pend_val(A - 2);
        return 0;
    endfunction

    function automatic int reload_of(input int f);
        case (f)
            0: return 0;
            1: return 1;
            2: return 2;
            3: return 5;
            default: return 7;
        endcase
    endfunction

    initial begin
        lc_reload = 8'(reload_of(0));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        chk(dot_count == 0, "R9 dot", dot_count, 0);
        chk(line_count == 0, "R9 line", line_count, 0);
        chk(irq == 0, "R9 irq", irq, 0);
        chk(scroll_eff == 0, "R9 scroll", scroll_eff, 0);
        chk(region == 0 && v_active == 1, "R9 region", region, 0);
        rst = 1'b0;
        for (int k = 1; k <= NF * T * LD; k++) begin
            int d, ln, f, eirq;
            @(negedge clk);
            d  = k % LD;
            ln = (k / LD) % T;
            f  = k / (LD * T);
            chk(dot_count == 9'(d), "R1 dot", dot_count, d);
            chk(line_count == 9'(ln), "R1 line", line_count, ln);
            chk(region == 3'(exp_region(d)), "R2 region", region, exp_region(d));
            chk(v_active == (ln < A), "R2 vactive", v_active, int'(ln < A));
            if (k < 600)
                chk(d1 == 9'(k / 3), "R1 divider", d1, k / 3);
            eirq = int'(fires(ln, reload_of(f)) || ln == A + 1);
            if (d == 5 || d == 10) begin
                if (ln == A + 1)      chk(irq == eirq[0], "R5 frame irq", irq, eirq);
                else if (ln == 0 || ln > A)
                                      chk(irq == eirq[0], "R4 no line irq", irq, eirq);
                else                  chk(irq == eirq[0], "R3 line irq", irq, eirq);
            end
            if (d == 22) chk(irq == 1'b0, "R8 ack clears", irq, 0);
            if (d == 5 || d == 300) begin
                if (ln == 0 || ln > A)
                    chk(scroll_eff == 8'(exp_scroll(ln)), "R7 scroll reset", scroll_eff, exp_scroll(ln));
                else
                    chk(scroll_eff == 8'(exp_scroll(ln)), "R6 scroll latch", scroll_eff, exp_scroll(ln));
            end
            if (d == 20) irq_ack = 1'b1;
            if (d == 21) irq_ack = 1'b0;
            if (d == 100) scroll_pend = 8'(pend_val(ln));
            if (d == 100 && ln == T - 1) lc_reload = 8'(reload_of(f + 1));
        end
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 40000);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule